// File: doc/BRIEF.md
# Chaotic Attractor RK4 Step Engine

This block advances the three-variable simplified Lorenz system one integration step at a time. The solver is classical fourth-order Runge–Kutta in signed Q8.24 fixed point. The state (x, y, z), the system parameter c and the step size T sit in a small register bank that can be written while the engine is idle. After each step the block presents the new state with a one-cycle `out_valid_o` strobe and keeps it as the starting point of the next step.

All arithmetic goes through one shared multiplier. A saturating adder/subtractor follows it, and a fixed micro-sequence of 51 operations drives the pair. Each step therefore takes exactly 51 busy cycles. In single-step mode a `start_i` pulse runs one step. In free-run mode a new step begins whenever the engine is idle and the downstream `ready_i` is high, which gives one result every 52 cycles.

Top module: `rk_lorenz_iter`

## Requirements
- R1: After reset, x_o/y_o/z_o read 1677722, 3355443, 5033165 (0.1, 0.2, 0.3 in Q8.24), c is 83886080 (5.0) and T is 167772 (0.01). busy_o and out_valid_o are low.
- R2: A value v means v/2^24 (signed, 32 bits). Every product is the exact 64-bit product plus 2^23, shifted right arithmetically by 24 and clamped to [-2^31, 2^31-1]. Every sum or difference is exact and then clamped to the same range.
- R3: One step computes, in this order: coef = 24 - mul(4,c), h = mul(T,0.5), t6 = mul(T,k6), where k6 = 2796203. For each of the four stages at point p (p = s at stage 0) it computes:
  - kx = mul(10, py-px)
  - ky = (mul(coef,px) - mul(px,pz)) + mul(c,py)
  - kz = mul(px,py) - mul(k83,pz), where k83 = 44739243
  - acc = acc + mul(w,k), with w = 1.0 for stages 0 and 3, w = 2.0 for stages 1 and 2, and acc starting at 0
  - for stages 0 to 2, the next point is s + mul(g,k), with g = h for stages 0 and 1 and g = T for stage 2

  Finally s = s + mul(t6,acc) per component.
- R4: Each step starts from the state produced by the previous step.
- R5: busy_o rises on the clock edge that accepts a step and stays high for exactly 51 cycles. out_valid_o is a single-cycle pulse on the first cycle with busy_o low again, and x_o/y_o/z_o then hold the new state.
- R6: While busy_o is low, a write with cfg_we_i loads cfg_wdata_i into x (address 0), y (1), z (2), c (3) or T (4). Other addresses change nothing. Writes while busy_o is high are ignored. A start request in the same cycle as a write is dropped.
- R7: start_i, free_run_i and ready_i have no effect while busy_o is high.
- R8: With free_run_i high, a step begins on every edge at which the engine is idle and ready_i is high, so results arrive every 52 cycles. With ready_i low, no step begins.
- R9: With free_run_i low, a step begins only on a start_i pulse, and the engine stays idle after out_valid_o.
- R10: Values of c outside the chaotic range (-1.59 to 7.75) are accepted and integrated by the same rules.
- R11: While the engine stays idle and no write is made, x_o/y_o/z_o do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register select (0 x, 1 y, 2 z, 3 c, 4 T) |
| cfg_wdata_i | input | 32 | Register write data, Q8.24 |
| start_i | input | 1 | Request one step |
| free_run_i | input | 1 | Step continuously while ready_i is high |
| ready_i | input | 1 | Downstream can take another result |
| busy_o | output | 1 | Step in progress |
| out_valid_o | output | 1 | One-cycle strobe: new state on x_o/y_o/z_o |
| x_o | output | 32 | State x, Q8.24 |
| y_o | output | 32 | State y, Q8.24 |
| z_o | output | 32 | State z, Q8.24 |

## Verification
The checks on the strobe and on idle stability assume three things about the inputs. Writes and start requests come from one agent. Writes are only intended for idle periods. A start request is not issued in the same cycle as a write. The bench drives every input on the falling edge. It writes configuration only while busy_o is low, except in the one scenario that deliberately writes and restarts mid-step to confirm they are ignored. The bench never combines a write with a start request. The bench's reference model rebuilds each step from the rounding, saturation and operation order in R2 and R3, so only a bit-exact match counts.

// File: rtl/rk_lorenz_pkg.sv
package rk_lorenz_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_EVAL, ST_FINAL} stage_e;

  // operand / destination index: 0..16 are registers, the rest are constants
  typedef enum logic [4:0] {
    R_SX, R_SY, R_SZ, R_PX, R_PY, R_PZ, R_KX, R_KY, R_KZ,
    R_AX, R_AY, R_AZ, R_COEF, R_HALF, R_T6, R_C, R_T,
    K_DIFF, K_TEN, K_EIGHT3, K_FOUR, K_TWENTY4, K_SIXTH,
    K_HALF, K_ONE, K_TWO, K_ZERO
  } opnd_e;

  localparam int NREG  = 17;
  localparam int NOPND = 27;

  typedef struct packed {
    opnd_e a;
    opnd_e b;
    opnd_e x;    // post-operand: y = x +/- a*b
    logic  sub;
    opnd_e dst;
    logic  we;
  } uop_t;

endpackage

// File: rtl/rk_sat_add.sv
module rk_sat_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] y_o
);
  logic signed [W:0] s;

  always_comb begin
    s = sub_i ? ($signed({a_i[W-1], a_i}) - $signed({b_i[W-1], b_i}))
              : ($signed({a_i[W-1], a_i}) + $signed({b_i[W-1], b_i}));
    if (s[W] != s[W-1]) y_o = s[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else                y_o = s[W-1:0];
  end
endmodule

// File: rtl/rk_fx_unit.sv
module rk_fx_unit #(
  parameter int W    = 32,
  parameter int FRAC = 24
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] x_i,
  input  logic         sub_i,
  output logic [W-1:0] y_o
);
  localparam int PW = 2 * W;
  localparam logic signed [PW-1:0] RND = PW'(1) << (FRAC - 1);

  logic signed [PW-1:0] prod, shf;
  logic [W-1:0] m;

  always_comb begin
    prod = $signed(a_i) * $signed(b_i);
    shf  = (prod + RND) >>> FRAC;
    if (&shf[PW-1:W-1] || ~|shf[PW-1:W-1]) m = shf[W-1:0];
    else m = shf[PW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
  end

  rk_sat_add #(.W(W)) u_post (.a_i(x_i), .b_i(m), .sub_i(sub_i), .y_o(y_o));
endmodule

// File: rtl/rk_seq.sv
module rk_seq
  import rk_lorenz_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output uop_t uop_o,
  output logic busy_o,
  output logic done_o
);
  stage_e     st;
  logic [3:0] cnt;
  logic [1:0] ev;
  logic       last_eval;

  function automatic opnd_e lane(opnd_e base, logic [1:0] i);
    return opnd_e'(5'(base) + {3'b000, i});
  endfunction

  assign last_eval = (ev == 2'd3) ? (cnt == 4'd8) : (cnt == 4'd11);
  assign busy_o    = (st != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; cnt <= '0; ev <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        ST_IDLE: if (go_i) begin st <= ST_SETUP; cnt <= '0; ev <= '0; end
        ST_SETUP: begin
          if (cnt == 4'd2) begin st <= ST_EVAL; cnt <= '0; end
          else cnt <= cnt + 4'd1;
        end
        ST_EVAL: begin
          if (last_eval) begin
            cnt <= '0;
            if (ev == 2'd3) st <= ST_FINAL;
            else ev <= ev + 2'd1;
          end else cnt <= cnt + 4'd1;
        end
        ST_FINAL: begin
          if (cnt == 4'd2) begin st <= ST_IDLE; done_o <= 1'b1; end
          else cnt <= cnt + 4'd1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    uop_o = '{a: K_ZERO, b: K_ZERO, x: K_ZERO, sub: 1'b0, dst: R_SX, we: 1'b0};
    unique case (st)
      ST_SETUP: begin
        uop_o.we = 1'b1;
        unique case (cnt)
          4'd0:    begin uop_o.a = K_FOUR; uop_o.b = R_C; uop_o.x = K_TWENTY4;
                         uop_o.sub = 1'b1; uop_o.dst = R_COEF; end
          4'd1:    begin uop_o.a = R_T; uop_o.b = K_HALF;  uop_o.dst = R_HALF; end
          default: begin uop_o.a = R_T; uop_o.b = K_SIXTH; uop_o.dst = R_T6; end
        endcase
      end
      ST_EVAL: begin
        uop_o.we = 1'b1;
        unique case (cnt)
          4'd0: begin uop_o.a = K_TEN;  uop_o.b = K_DIFF; uop_o.dst = R_KX; end
          4'd1: begin uop_o.a = R_COEF; uop_o.b = R_PX;   uop_o.dst = R_KY; end
          4'd2: begin uop_o.a = R_PX; uop_o.b = R_PZ; uop_o.x = R_KY;
                      uop_o.sub = 1'b1; uop_o.dst = R_KY; end
          4'd3: begin uop_o.a = R_C;  uop_o.b = R_PY; uop_o.x = R_KY; uop_o.dst = R_KY; end
          4'd4: begin uop_o.a = R_PX; uop_o.b = R_PY; uop_o.dst = R_KZ; end
          4'd5: begin uop_o.a = K_EIGHT3; uop_o.b = R_PZ; uop_o.x = R_KZ;
                      uop_o.sub = 1'b1; uop_o.dst = R_KZ; end
          4'd6, 4'd7, 4'd8: begin  // weighted accumulate
            uop_o.a   = (ev == 2'd1 || ev == 2'd2) ? K_TWO : K_ONE;
            uop_o.b   = lane(R_KX, cnt[1:0] - 2'd2);
            uop_o.x   = (ev == 2'd0) ? K_ZERO : lane(R_AX, cnt[1:0] - 2'd2);
            uop_o.dst = lane(R_AX, cnt[1:0] - 2'd2);
          end
          default: begin           // next evaluation point
            uop_o.a   = (ev == 2'd2) ? R_T : R_HALF;
            uop_o.b   = lane(R_KX, cnt[1:0] - 2'd1);
            uop_o.x   = lane(R_SX, cnt[1:0] - 2'd1);
            uop_o.dst = lane(R_PX, cnt[1:0] - 2'd1);
          end
        endcase
      end
      ST_FINAL: begin
        uop_o.we  = 1'b1;
        uop_o.a   = R_T6;
        uop_o.b   = lane(R_AX, cnt[1:0]);
        uop_o.x   = lane(R_SX, cnt[1:0]);
        uop_o.dst = lane(R_SX, cnt[1:0]);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rk_lorenz_iter.sv
module rk_lorenz_iter
  import rk_lorenz_pkg::*;
#(
  parameter int W    = 32,
  parameter int FRAC = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cfg_we_i,
  input  logic [2:0]   cfg_addr_i,
  input  logic [W-1:0] cfg_wdata_i,
  input  logic         start_i,
  input  logic         free_run_i,
  input  logic         ready_i,
  output logic         busy_o,
  output logic         out_valid_o,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic [W-1:0] z_o
);
  localparam longint ONE_L = longint'(1) << FRAC;
  localparam logic [W-1:0] C_TEN  = W'(10 * ONE_L);
  localparam logic [W-1:0] C_83   = W'((16 * ONE_L + 3) / 6);
  localparam logic [W-1:0] C_FOUR = W'(4 * ONE_L);
  localparam logic [W-1:0] C_24   = W'(24 * ONE_L);
  localparam logic [W-1:0] C_6TH  = W'((2 * ONE_L + 6) / 12);
  localparam logic [W-1:0] C_HALF = W'(ONE_L / 2);
  localparam logic [W-1:0] C_ONE  = W'(ONE_L);
  localparam logic [W-1:0] C_TWO  = W'(2 * ONE_L);
  localparam logic [W-1:0] X_DEF  = W'((ONE_L + 5) / 10);
  localparam logic [W-1:0] Y_DEF  = W'((2 * ONE_L + 5) / 10);
  localparam logic [W-1:0] Z_DEF  = W'((3 * ONE_L + 5) / 10);
  localparam logic [W-1:0] CP_DEF = W'(5 * ONE_L);
  localparam logic [W-1:0] T_DEF  = W'((ONE_L + 50) / 100);

  logic [W-1:0] rf  [NREG];
  logic [W-1:0] opv [NOPND];
  logic [W-1:0] diff, res;
  uop_t uop;
  logic go;

  assign go = !busy_o && !cfg_we_i && (start_i || (free_run_i && ready_i));

  rk_seq u_seq (.clk_i, .rst_ni, .go_i(go), .uop_o(uop), .busy_o, .done_o(out_valid_o));

  rk_sat_add #(.W(W)) u_diff (.a_i(rf[R_PY]), .b_i(rf[R_PX]), .sub_i(1'b1), .y_o(diff));

  always_comb begin
    for (int i = 0; i < NREG; i++) opv[i] = rf[i];
    opv[K_DIFF]    = diff;
    opv[K_TEN]     = C_TEN;
    opv[K_EIGHT3]  = C_83;
    opv[K_FOUR]    = C_FOUR;
    opv[K_TWENTY4] = C_24;
    opv[K_SIXTH]   = C_6TH;
    opv[K_HALF]    = C_HALF;
    opv[K_ONE]     = C_ONE;
    opv[K_TWO]     = C_TWO;
    opv[K_ZERO]    = '0;
  end

  rk_fx_unit #(.W(W), .FRAC(FRAC)) u_alu (
    .a_i(opv[uop.a]), .b_i(opv[uop.b]), .x_i(opv[uop.x]), .sub_i(uop.sub), .y_o(res));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      rf[R_SX] <= X_DEF; rf[R_SY] <= Y_DEF; rf[R_SZ] <= Z_DEF;
      rf[R_C]  <= CP_DEF; rf[R_T] <= T_DEF;
    end else begin
      if (cfg_we_i && !busy_o) begin
        unique case (cfg_addr_i)
          3'd0: rf[R_SX] <= cfg_wdata_i;
          3'd1: rf[R_SY] <= cfg_wdata_i;
          3'd2: rf[R_SZ] <= cfg_wdata_i;
          3'd3: rf[R_C]  <= cfg_wdata_i;
          3'd4: rf[R_T]  <= cfg_wdata_i;
          default: ;
        endcase
      end else if (go) begin
        rf[R_PX] <= rf[R_SX]; rf[R_PY] <= rf[R_SY]; rf[R_PZ] <= rf[R_SZ];
      end
      if (uop.we) rf[uop.dst] <= res;
    end
  end

  assign x_o = rf[R_SX];
  assign y_o = rf[R_SY];
  assign z_o = rf[R_SZ];
endmodule

// File: rtl/rk_lorenz_chk.sv
module rk_lorenz_chk #(
  parameter int W           = 32,
  parameter int STEP_CYCLES = 51
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cfg_we_i,
  input logic         start_i,
  input logic         free_run_i,
  input logic         ready_i,
  input logic         busy_o,
  input logic         out_valid_o,
  input logic [W-1:0] x_o,
  input logic [W-1:0] y_o,
  input logic [W-1:0] z_o
);
  logic [7:0] bcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bcnt <= '0;
    else         bcnt <= busy_o ? bcnt + 8'd1 : 8'd0;
  end

  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !busy_o);  // R5
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);  // R5
  AST_STEP_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (bcnt == 8'(STEP_CYCLES)));  // R5
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> out_valid_o);  // R5
  AST_BUSY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i || (free_run_i && ready_i)));  // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o) && !$past(cfg_we_i)) |-> $stable({x_o, y_o, z_o}));  // R11
endmodule

bind rk_lorenz_iter rk_lorenz_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .start_i(start_i),
  .free_run_i(free_run_i), .ready_i(ready_i), .busy_o(busy_o),
  .out_valid_o(out_valid_o), .x_o(x_o), .y_o(y_o), .z_o(z_o));

// File: tb/tb_rk_lorenz_iter.sv
module tb_rk_lorenz_iter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic        start = 0, free_run = 0, ready = 0;
  logic        busy, out_valid;
  logic [31:0] x, y, z;

  int checks = 0, fails = 0;
  bit finished = 0;

  // model state and constants
  logic signed [31:0] m_x, m_y, m_z, m_c, m_t;
  localparam logic signed [31:0] Q_ONE = 32'sd16777216, Q_TWO = 32'sd33554432;
  localparam logic signed [31:0] Q_TEN = 32'sd167772160, Q_FOUR = 32'sd67108864;
  localparam logic signed [31:0] Q_24 = 32'sd402653184, Q_83 = 32'sd44739243;
  localparam logic signed [31:0] Q_6TH = 32'sd2796203, Q_HALF = 32'sd8388608;

  always #5 clk = ~clk;

  rk_lorenz_iter dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .start_i(start), .free_run_i(free_run), .ready_i(ready),
    .busy_o(busy), .out_valid_o(out_valid), .x_o(x), .y_o(y), .z_o(z));

  function automatic logic signed [31:0] clamp(logic signed [65:0] v);
    if (v > 66'sd2147483647) return 32'sh7fffffff;
    if (v < -66'sd2147483648) return 32'sh80000000;
    return v[31:0];
  endfunction
  function automatic logic signed [31:0] fmul(logic signed [31:0] a, logic signed [31:0] b);
    logic signed [65:0] p;
    p = 66'(a) * 66'(b);
    return clamp((p + 66'sd8388608) >>> 24);
  endfunction
  function automatic logic signed [31:0] fadd(logic signed [31:0] a, logic signed [31:0] b);
    return clamp(66'(a) + 66'(b));
  endfunction
  function automatic logic signed [31:0] fsub(logic signed [31:0] a, logic signed [31:0] b);
    return clamp(66'(a) - 66'(b));
  endfunction

  // R3 reference step on m_x/m_y/m_z
  task automatic ref_step();
    logic signed [31:0] coef, hh, t6, px, py, pz, kx, ky, kz, ax, ay, az, w, g;
    coef = fsub(Q_24, fmul(Q_FOUR, m_c));
    hh = fmul(m_t, Q_HALF);
    t6 = fmul(m_t, Q_6TH);
    px = m_x; py = m_y; pz = m_z; ax = 0; ay = 0; az = 0;
    for (int e = 0; e < 4; e++) begin
      kx = fmul(Q_TEN, fsub(py, px));
      ky = fmul(coef, px);
      ky = fsub(ky, fmul(px, pz));
      ky = fadd(ky, fmul(m_c, py));
      kz = fmul(px, py);
      kz = fsub(kz, fmul(Q_83, pz));
      w = (e == 1 || e == 2) ? Q_TWO : Q_ONE;
      ax = fadd(ax, fmul(w, kx));
      ay = fadd(ay, fmul(w, ky));
      az = fadd(az, fmul(w, kz));
      if (e < 3) begin
        g = (e == 2) ? m_t : hh;
        px = fadd(m_x, fmul(g, kx));
        py = fadd(m_y, fmul(g, ky));
        pz = fadd(m_z, fmul(g, kz));
      end
    end
    m_x = fadd(m_x, fmul(t6, ax));
    m_y = fadd(m_y, fmul(t6, ay));
    m_z = fadd(m_z, fmul(t6, az));
  endtask

  task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic load(logic [31:0] vx, logic [31:0] vy, logic [31:0] vz,
                      logic [31:0] vc, logic [31:0] vt);
    wr(3'd0, vx); wr(3'd1, vy); wr(3'd2, vz); wr(3'd3, vc); wr(3'd4, vt);
    m_x = vx; m_y = vy; m_z = vz; m_c = vc; m_t = vt;
  endtask

  // one start pulse; returns cycles from accept to out_valid
  task automatic step(output int n);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0; n = 0;
    while (!out_valid && n < 300) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    chk("R1 reset state", {x, y, z}, {32'd1677722, 32'd3355443, 32'd5033165});
    chk("R1 reset flags", {94'd0, busy, out_valid}, 96'd0);
  endtask

  task automatic t_single();
    int n;
    logic [95:0] held;
    step(n);
    chk("R5 step latency", 96'(n), 96'd51);
    ref_step();
    chk("R1 R2 R3 first step from defaults", {x, y, z}, {m_x, m_y, m_z});
    held = {x, y, z};
    repeat (80) @(negedge clk);
    chk("R9 stays idle after step", 96'(busy), 96'd0);
    chk("R11 outputs held while idle", {x, y, z}, held);
    step(n);
    ref_step();
    chk("R4 second step continues", {x, y, z}, {m_x, m_y, m_z});
  endtask

  task automatic t_cfg();
    int n;
    logic [95:0] held;
    held = {x, y, z};
    wr(3'd6, 32'h1234_5678);
    chk("R6 unused address ignored", {x, y, z}, held);
    step(n);
    ref_step();
    chk("R6 unused address leaves c and T", {x, y, z}, {m_x, m_y, m_z});
    // c = -3.0 (outside chaotic range), T = 0.02
    load(32'h0100_0000, 32'hFF80_0000, 32'h0200_0000, 32'hFD00_0000, 32'd335544);
    chk("R6 written state visible", {x, y, z}, {32'h0100_0000, 32'hFF80_0000, 32'h0200_0000});
    step(n);
    ref_step();
    chk("R10 R6 step with loaded c and T", {x, y, z}, {m_x, m_y, m_z});
  endtask

  task automatic t_busy_ignore();
    int n;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0; n = 0;
    repeat (3) begin @(negedge clk); n++; end
    cfg_we = 1; cfg_addr = 3'd0; cfg_wdata = 32'h0500_0000;
    @(negedge clk); n++; cfg_we = 0; start = 1; free_run = 1; ready = 1;
    @(negedge clk); n++; start = 0; free_run = 0; ready = 0;
    while (!out_valid && n < 300) begin @(negedge clk); n++; end
    chk("R7 restart during step ignored", 96'(n), 96'd51);
    ref_step();
    chk("R6 write during busy ignored", {x, y, z}, {m_x, m_y, m_z});
    repeat (10) @(negedge clk);
    chk("R7 no second step queued", 96'(busy), 96'd0);
  endtask

  task automatic t_sat();
    int n;
    load(32'h7FFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0500_0000, 32'd167772);
    step(n);
    ref_step();
    chk("R2 saturating extremes", {x, y, z}, {m_x, m_y, m_z});
  endtask

  task automatic t_freerun();
    int n;
    int bad;
    logic [95:0] held;
    load(32'd1677722, 32'd3355443, 32'd5033165, 32'd83886080, 32'd167772);
    @(negedge clk); free_run = 1; ready = 0;
    repeat (20) @(negedge clk);
    chk("R8 ready low holds off", 96'(busy), 96'd0);
    ready = 1;
    bad = 0;
    for (int s = 0; s < 1000; s++) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!out_valid && n < 300);
      ref_step();
      if (s == 999) ready = 0;
      chk("R4 R3 free-run step match", {x, y, z}, {m_x, m_y, m_z});
      if (s > 0 && n != 52) bad++;
    end
    chk("R8 free-run period 52", 96'(bad), 96'd0);
    held = {x, y, z};
    repeat (60) @(negedge clk);
    chk("R8 stops when ready low", {95'd0, busy}, 96'd0);
    chk("R11 state held after stop", {x, y, z}, held);
    free_run = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R5 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    m_x = 32'sd1677722; m_y = 32'sd3355443; m_z = 32'sd5033165;
    m_c = 32'sd83886080; m_t = 32'sd167772;
    t_reset();
    t_single();
    t_cfg();
    t_busy_ignore();
    t_sat();
    t_freerun();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule